// File: doc/BRIEF.md
# Privilege-Gated Interrupt Pending Arbiter

This block keeps pending interrupt requests for seven interrupt classes. Each class has a vector of source bits. Requesters raise a bit with a post request and drop it with a clear request, each given as a (class, source index) pair. Alongside the vectors the block keeps one summary bit per class. That bit is set while the class has any source pending.

From the registered pending state and three live processor flags, the block decides whether an interrupt should be taken now and which class wins. The flags are the hyper-privileged flag, the interrupt-enable flag and a trap-level-zero condition. The priority chain depends on the privilege mode. In hyper-privileged mode only two classes can win, and only while interrupts are enabled. Outside that mode three classes win whatever the enable flag says, and four more follow them once interrupts are enabled. When the software class wins, the block also reports a 4-bit level taken from that class's vector.

Any class vector can be read back through a combinational select port. A single clear-all request empties every vector and the summary word.

Top module: `irq_pend_arb`

## Requirements
- R1: After a synchronous active-low reset every vector and the summary word are zero, `take` is 0, `win_class` is 7 and `soft_level` is 0.
- R2: A post with `post_type` t and `post_idx` i sets bit i of vector t and bit t of `summary` at the next rising edge. Class codes are: 0 trap-level-zero, 1 hyper-stick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 resumable error, 6 software. A post with code 7 changes nothing.
- R3: A clear with `clr_type` t and `clr_idx` i resets bit i of vector t at the next edge. Bit t of `summary` drops only when vector t becomes all zero.
- R4: When a post and a clear name the same bit in the same cycle, the bit ends up set. `clr_all` zeroes all vectors and `summary` at the next edge, and it overrides any post or clear in the same cycle.
- R5: When `summary` is zero, `take` is 0. Whenever `take` is 0, `win_class` is 7.
- R6: When `hyper_priv` is 1, only class 1 and then class 2 can win, and only while `int_enable` is 1.
- R7: When `hyper_priv` is 0, the order starts with class 0, then class 1, then class 2, and these are taken regardless of `int_enable`. Class 0 is eligible only while `tlz_cond` is 1.
- R8: When `hyper_priv` is 0 and `int_enable` is 1, classes 3, 4, 6 and 5 follow, in that order.
- R9: While class 6 wins, `soft_level` is 14 if bit 16 or bit 0 of vector 6 is set. Otherwise it is the index of the highest set bit among bits 15..1, and 0 if none of those bits is set. While any other class wins, or nothing wins, `soft_level` is 0.
- R10: `rd_vec` shows vector `rd_type` combinationally. For `rd_type` 7 it shows zero.
- R11: `take`, `win_class` and `soft_level` follow changes of `hyper_priv`, `int_enable` and `tlz_cond` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Post request strobe |
| post_type | input | 3 | Class code of the post |
| post_idx | input | 6 | Source index of the post |
| clr_en | input | 1 | Clear request strobe |
| clr_type | input | 3 | Class code of the clear |
| clr_idx | input | 6 | Source index of the clear |
| clr_all | input | 1 | Empty every vector and the summary word |
| hyper_priv | input | 1 | Hyper-privileged mode flag |
| int_enable | input | 1 | Interrupt-enable flag |
| tlz_cond | input | 1 | Trap-level-zero condition |
| rd_type | input | 3 | Class select for readback |
| rd_vec | output | 64 | Pending vector of the selected class |
| summary | output | 7 | Per-class summary bits |
| take | output | 1 | An interrupt should be taken |
| win_class | output | 3 | Winning class code, 7 when none |
| soft_level | output | 4 | Software interrupt level |

## Verification
Post, clear and clear-all requests are registered, so their effect on `summary`, `rd_vec` and the arbitration outputs is due one rising edge after the request. The bench drives each request just after an edge and samples one time unit after the next edge. The flag inputs and `rd_type` act combinationally: the bench changes them, waits one time unit with no clock edge, and checks the outputs in that same cycle. An exhaustive sweep covers all 128 pending-class patterns against all eight flag combinations, and every single-bit position of the software vector is swept for the level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Class codes shared by the post, clear, readback and winner ports
    localparam int NUM_CLASSES = 7;
    localparam int CLS_W       = 3;

    localparam logic [CLS_W-1:0] CLS_TLZ    = 3'd0;
    localparam logic [CLS_W-1:0] CLS_HSTICK = 3'd1;
    localparam logic [CLS_W-1:0] CLS_IVEC   = 3'd2;
    localparam logic [CLS_W-1:0] CLS_CPUM   = 3'd3;
    localparam logic [CLS_W-1:0] CLS_DEVM   = 3'd4;
    localparam logic [CLS_W-1:0] CLS_RESERR = 3'd5;
    localparam logic [CLS_W-1:0] CLS_SOFT   = 3'd6;
    localparam logic [CLS_W-1:0] CLS_NONE   = 3'd7;

    localparam int LVL_W = 4;

    // Result of one arbitration pass
    typedef struct packed {
        logic             take;
        logic [CLS_W-1:0] cls;
    } arb_result_t;

endpackage

// File: rtl/irq_pend_bank.sv
// irq_pend_bank
// Holds the pending source vector of one interrupt class and its summary
// bit. Assumes post/clear hits are already decoded for this class. A post
// beats a clear of the same bit; clear-all beats both.
module irq_pend_bank #(
    parameter int VEC_W = 64,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             post_hit,
    input  logic [IDX_W-1:0] post_idx,
    input  logic             clr_hit,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [VEC_W-1:0] vec,
    output logic             pend
);

    logic [VEC_W-1:0] post_mask;
    logic [VEC_W-1:0] clr_mask;
    logic [VEC_W-1:0] vec_next;
    logic             pend_next;

    // Decode the one-hot post and clear masks
    always_comb begin
        post_mask = '0;
        clr_mask  = '0;
        if (post_hit) post_mask[post_idx] = 1'b1;
        if (clr_hit)  clr_mask[clr_idx]   = 1'b1;
    end

    // Next vector: clear first, then post, so a colliding post survives
    always_comb begin
        if (clr_all) vec_next = '0;
        else         vec_next = (vec & ~clr_mask) | post_mask;
    end

    // Summary bit: set on post, dropped only when a clear empties the vector
    always_comb begin
        pend_next = pend;
        if (clr_all)                           pend_next = 1'b0;
        else if (post_hit)                     pend_next = 1'b1;
        else if (clr_hit && (vec_next == '0))  pend_next = 1'b0;
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec  <= '0;
            pend <= 1'b0;
        end else begin
            vec  <= vec_next;
            pend <= pend_next;
        end
    end

endmodule

// File: rtl/irq_soft_level.sv
// irq_soft_level
// Derives the software interrupt level from that class's vector. Bit 16 or
// bit 0 forces level 14; otherwise the highest set bit of 15..1 is the level,
// else 0. Assumes VEC_W >= 17.
module irq_soft_level #(
    parameter int VEC_W = 64,
    parameter int LVL_W = 4,
    localparam int TOP_BIT   = (1 << LVL_W) - 1,
    localparam int FORCE_LVL = 14,
    localparam int FORCE_HI  = 16
) (
    input  logic [VEC_W-1:0] vec,
    output logic [LVL_W-1:0] level
);

    // Priority scan from bit 1 upward so the highest set bit is kept last
    always_comb begin
        level = '0;
        if (vec[FORCE_HI] || vec[0]) begin
            level = LVL_W'(FORCE_LVL);
        end else begin
            for (int b = 1; b <= TOP_BIT; b++) begin
                if (vec[b]) level = LVL_W'(b);
            end
        end
    end

endmodule

// File: rtl/irq_prio_sel.sv
// irq_prio_sel
// Fixed privilege-dependent priority selection over the per-class summary
// bits. Purely combinational; assumes pend bits come from registered state.
module irq_prio_sel
    import irq_arb_pkg::*;
(
    input  logic [NUM_CLASSES-1:0] pend,
    input  logic                   hyper_priv,
    input  logic                   int_enable,
    input  logic                   tlz_cond,
    output arb_result_t            res
);

    // Walk the chain for the current mode; the first eligible class wins
    always_comb begin
        res.take = 1'b0;
        res.cls  = CLS_NONE;
        if (pend != '0) begin
            if (hyper_priv) begin
                if (int_enable) begin
                    if (pend[CLS_HSTICK]) begin
                        res.take = 1'b1; res.cls = CLS_HSTICK;
                    end else if (pend[CLS_IVEC]) begin
                        res.take = 1'b1; res.cls = CLS_IVEC;
                    end
                end
            end else begin
                if (pend[CLS_TLZ] && tlz_cond) begin
                    res.take = 1'b1; res.cls = CLS_TLZ;
                end else if (pend[CLS_HSTICK]) begin
                    res.take = 1'b1; res.cls = CLS_HSTICK;
                end else if (pend[CLS_IVEC]) begin
                    res.take = 1'b1; res.cls = CLS_IVEC;
                end else if (int_enable) begin
                    if (pend[CLS_CPUM]) begin
                        res.take = 1'b1; res.cls = CLS_CPUM;
                    end else if (pend[CLS_DEVM]) begin
                        res.take = 1'b1; res.cls = CLS_DEVM;
                    end else if (pend[CLS_SOFT]) begin
                        res.take = 1'b1; res.cls = CLS_SOFT;
                    end else if (pend[CLS_RESERR]) begin
                        res.take = 1'b1; res.cls = CLS_RESERR;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_pend_arb.sv
// irq_pend_arb
// Top level: one pending bank per class, readback mux, priority selection and
// software level. Requests register on the next edge; outputs are
// combinational from registered state and the live mode flags.
module irq_pend_arb
    import irq_arb_pkg::*;
#(
    parameter int VEC_W = 64,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   post_en,
    input  logic [CLS_W-1:0]       post_type,
    input  logic [IDX_W-1:0]       post_idx,
    input  logic                   clr_en,
    input  logic [CLS_W-1:0]       clr_type,
    input  logic [IDX_W-1:0]       clr_idx,
    input  logic                   clr_all,
    input  logic                   hyper_priv,
    input  logic                   int_enable,
    input  logic                   tlz_cond,
    input  logic [CLS_W-1:0]       rd_type,
    output logic [VEC_W-1:0]       rd_vec,
    output logic [NUM_CLASSES-1:0] summary,
    output logic                   take,
    output logic [CLS_W-1:0]       win_class,
    output logic [LVL_W-1:0]       soft_level
);

    logic [VEC_W-1:0] vecs [NUM_CLASSES];
    logic [LVL_W-1:0] lvl_raw;
    arb_result_t      res;

    // One bank per class, each decoding its own post/clear hit
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bank
        irq_pend_bank #(.VEC_W(VEC_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_all  (clr_all),
            .post_hit (post_en && (post_type == CLS_W'(c))),
            .post_idx (post_idx),
            .clr_hit  (clr_en && (clr_type == CLS_W'(c))),
            .clr_idx  (clr_idx),
            .vec      (vecs[c]),
            .pend     (summary[c])
        );
    end

    // Readback select; an unused code reads as zero
    always_comb begin
        rd_vec = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (rd_type == CLS_W'(c)) rd_vec = vecs[c];
        end
    end

    irq_prio_sel prio_i (
        .pend       (summary),
        .hyper_priv (hyper_priv),
        .int_enable (int_enable),
        .tlz_cond   (tlz_cond),
        .res        (res)
    );

    irq_soft_level #(.VEC_W(VEC_W), .LVL_W(LVL_W)) lvl_i (
        .vec   (vecs[CLS_SOFT]),
        .level (lvl_raw)
    );

    // Drive the arbitration outputs; level only shown for a software winner
    always_comb begin
        take       = res.take;
        win_class  = res.cls;
        soft_level = (res.take && res.cls == CLS_SOFT) ? lvl_raw : '0;
    end

endmodule

// irq_arb_chk
// Property checker bound to irq_pend_arb; observes ports only.
module irq_arb_chk
    import irq_arb_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   post_en,
    input logic [CLS_W-1:0]       post_type,
    input logic                   clr_all,
    input logic                   hyper_priv,
    input logic                   int_enable,
    input logic                   tlz_cond,
    input logic [NUM_CLASSES-1:0] summary,
    input logic                   take,
    input logic [CLS_W-1:0]       win_class,
    input logic [LVL_W-1:0]       soft_level
);

    a_r2_post_sets_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && !clr_all && post_type != CLS_NONE)
        |=> (((summary >> $past(post_type)) & 7'd1) == 7'd1));

    a_r4_clear_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (summary == '0));

    a_r5_no_take_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (summary == '0) |-> !take);

    a_r5_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (win_class == CLS_NONE));

    a_r6_hyper_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (hyper_priv && !int_enable) |-> !take);

    a_r6_hyper_classes: assert property (@(posedge clk) disable iff (!rst_n)
        (hyper_priv && take) |-> (win_class == CLS_HSTICK || win_class == CLS_IVEC));

    a_r7_tlz_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_class == CLS_TLZ) |-> (tlz_cond && !hyper_priv));

    a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !int_enable) |-> (win_class <= CLS_IVEC));

    a_r9_level_only_soft: assert property (@(posedge clk) disable iff (!rst_n)
        (win_class != CLS_SOFT) |-> (soft_level == '0));

endmodule

bind irq_pend_arb irq_arb_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_en    (post_en),
    .post_type  (post_type),
    .clr_all    (clr_all),
    .hyper_priv (hyper_priv),
    .int_enable (int_enable),
    .tlz_cond   (tlz_cond),
    .summary    (summary),
    .take       (take),
    .win_class  (win_class),
    .soft_level (soft_level)
);

// File: tb/irq_pend_arb_tb.sv
module irq_pend_arb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        post_en, clr_en, clr_all;
    logic [2:0]  post_type, clr_type, rd_type;
    logic [5:0]  post_idx, clr_idx;
    logic        hyper_priv, int_enable, tlz_cond;
    logic [63:0] rd_vec;
    logic [6:0]  summary;
    logic        take;
    logic [2:0]  win_class;
    logic [3:0]  soft_level;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // Bench-side model of the pending vectors
    logic [63:0] mv [7];

    always #4 clk = ~clk;   // 125 MHz

    irq_pend_arb dut_i (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_type(post_type), .post_idx(post_idx),
        .clr_en(clr_en), .clr_type(clr_type), .clr_idx(clr_idx),
        .clr_all(clr_all),
        .hyper_priv(hyper_priv), .int_enable(int_enable), .tlz_cond(tlz_cond),
        .rd_type(rd_type), .rd_vec(rd_vec), .summary(summary),
        .take(take), .win_class(win_class), .soft_level(soft_level)
    );

    // Watchdog: an overlong run counts as one failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic model_clear_all();
        for (int t = 0; t < 7; t++) mv[t] = '0;
    endtask

    task automatic do_clear_all();
        clr_all = 1'b1; tick(); clr_all = 1'b0;
        model_clear_all();
    endtask

    task automatic do_post(input logic [2:0] t, input logic [5:0] i);
        post_en = 1'b1; post_type = t; post_idx = i; tick(); post_en = 1'b0;
        if (t != 3'd7) mv[t][i] = 1'b1;
    endtask

    task automatic do_clear(input logic [2:0] t, input logic [5:0] i);
        clr_en = 1'b1; clr_type = t; clr_idx = i; tick(); clr_en = 1'b0;
        if (t != 3'd7) mv[t][i] = 1'b0;
    endtask

    function automatic logic [3:0] exp_level(input logic [63:0] v);
        if (v[16] || v[0]) return 4'd14;
        for (int b = 15; b >= 1; b--) if (v[b]) return 4'(b);
        return 4'd0;
    endfunction

    // Expected {take, class, level} from the model and flags
    function automatic logic [7:0] exp_arb(input bit hp, input bit ie, input bit tz);
        logic [6:0] p;
        logic [2:0] c;
        for (int t = 0; t < 7; t++) p[t] = (mv[t] != 0);
        c = 3'd7;
        if (hp) begin
            if (ie) begin
                if (p[1]) c = 3'd1; else if (p[2]) c = 3'd2;
            end
        end else begin
            if (p[0] && tz) c = 3'd0;
            else if (p[1]) c = 3'd1;
            else if (p[2]) c = 3'd2;
            else if (ie) begin
                if (p[3]) c = 3'd3;
                else if (p[4]) c = 3'd4;
                else if (p[6]) c = 3'd6;
                else if (p[5]) c = 3'd5;
            end
        end
        return {(c != 3'd7), c, (c == 3'd6) ? exp_level(mv[6]) : 4'd0};
    endfunction

    function automatic logic [6:0] exp_summary();
        logic [6:0] s;
        for (int t = 0; t < 7; t++) s[t] = (mv[t] != 0);
        return s;
    endfunction

    task automatic check_arb(input string req);
        logic [7:0] e;
        e = exp_arb(hyper_priv, int_enable, tlz_cond);
        check({take, win_class, soft_level} == e, req, 64'({take, win_class, soft_level}), 64'(e));
    endtask

    initial begin
        rst_n = 1'b0; post_en = 0; clr_en = 0; clr_all = 0;
        post_type = 0; clr_type = 0; post_idx = 0; clr_idx = 0;
        hyper_priv = 0; int_enable = 1; tlz_cond = 1; rd_type = 0;
        model_clear_all();
        repeat (3) tick();
        rst_n = 1'b1;
        #1;

        // R1: reset state
        check(summary == 0, "R1 summary", 64'(summary), 0);
        check(take == 0 && win_class == 3'd7 && soft_level == 0, "R1 outputs",
              64'({take, win_class, soft_level}), 64'({1'b0, 3'd7, 4'd0}));
        for (int t = 0; t < 8; t++) begin
            rd_type = 3'(t); #1;
            check(rd_vec == 0, "R1 vector", rd_vec, 0);
        end

        // R2/R10: post into every class and read back
        for (int t = 0; t < 7; t++) begin
            do_post(3'(t), 6'(t * 9 + 1));
            rd_type = 3'(t); #1;
            check(rd_vec == mv[t], "R2 R10 readback", rd_vec, mv[t]);
            check(summary == exp_summary(), "R2 summary", 64'(summary), 64'(exp_summary()));
        end
        do_clear_all();
        check(summary == 0, "R4 clear-all", 64'(summary), 0);
        // R2: code 7 ignored
        do_post(3'd7, 6'd5);
        check(summary == 0, "R2 code 7 post", 64'(summary), 0);
        rd_type = 3'd7; #1;
        check(rd_vec == 0, "R10 code 7 readback", rd_vec, 0);

        // R3: partial clear keeps summary, final clear drops it
        do_post(3'd3, 6'd10);
        do_post(3'd3, 6'd40);
        do_clear(3'd3, 6'd10);
        rd_type = 3'd3; #1;
        check(summary[3] == 1'b1, "R3 summary kept", 64'(summary), 64'(exp_summary()));
        check(rd_vec == (64'd1 << 40), "R3 bit cleared", rd_vec, 64'd1 << 40);
        do_clear(3'd3, 6'd40);
        check(summary[3] == 1'b0, "R3 summary dropped", 64'(summary), 0);

        // R4: post/clear collision -> set
        post_en = 1; post_type = 3'd4; post_idx = 6'd63;
        clr_en = 1; clr_type = 3'd4; clr_idx = 6'd63;
        tick(); post_en = 0; clr_en = 0; mv[4][63] = 1'b1;
        rd_type = 3'd4; #1;
        check(rd_vec == (64'd1 << 63), "R4 collision post wins", rd_vec, 64'd1 << 63);
        // R4: clear-all overrides a same-cycle post
        clr_all = 1; post_en = 1; post_type = 3'd1; post_idx = 6'd2;
        tick(); clr_all = 0; post_en = 0; model_clear_all();
        check(summary == 0, "R4 clear-all over post", 64'(summary), 0);

        // R5-R8, R11: every pending pattern against every flag combination
        for (int m = 0; m < 128; m++) begin
            do_clear_all();
            for (int t = 0; t < 7; t++)
                if (m[t]) do_post(3'(t), (t == 6) ? 6'(m % 20) : 6'((m * 7 + t) % 64));
            check(summary == exp_summary(), "R2 sweep summary", 64'(summary), 64'(exp_summary()));
            for (int f = 0; f < 8; f++) begin
                hyper_priv = f[2]; int_enable = f[1]; tlz_cond = f[0];
                #1;
                check_arb("R5 R6 R7 R8 R11 arbitration");
            end
        end

        // R9: every single soft bit, then mixed cases
        hyper_priv = 0; int_enable = 1; tlz_cond = 0;
        for (int b = 0; b < 64; b++) begin
            do_clear_all();
            do_post(3'd6, 6'(b));
            check(soft_level == exp_level(mv[6]) && win_class == 3'd6, "R9 single bit level",
                  64'(soft_level), 64'(exp_level(mv[6])));
        end
        do_clear_all(); do_post(3'd6, 6'd5); do_post(3'd6, 6'd16);
        check(soft_level == 4'd14, "R9 bit16 forces 14", 64'(soft_level), 14);
        do_clear_all(); do_post(3'd6, 6'd3); do_post(3'd6, 6'd9);
        check(soft_level == 4'd9, "R9 highest bit", 64'(soft_level), 9);
        do_clear_all(); do_post(3'd6, 6'd15); do_post(3'd6, 6'd0);
        check(soft_level == 4'd14, "R9 bit0 forces 14", 64'(soft_level), 14);
        do_post(3'd3, 6'd1);
        check(soft_level == 4'd0 && win_class == 3'd3, "R9 level hidden for other winner",
              64'({win_class, soft_level}), 64'({3'd3, 4'd0}));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule